// File: doc/BRIEF.md
# Tearing-Synchronized Frame Transfer Controller

This block starts and ends the transfer of one rectangular pixel region to a command-mode display over a parallel bus. Software writes a control word together with a pixel count, which is the width times the height of the region. The block then either begins streaming at once or waits for the panel's tearing-effect (TE) pulse. In the line-qualified mode it also waits for a programmed number of horizontal sync pulses after TE. Both panel inputs go through a two-flop synchronizer. A pulse only counts once it has stayed at its active level for a programmed number of clocks.

While the transfer runs, the block offers beats to a downstream bus engine through a valid/ready pair and counts each accepted beat. After the last beat it drops back to idle on its own, which clears the enable. At the same time it raises a one-clock frame-done pulse. The selected chip select is shown on an output for the whole transfer.

The state machine has four states:
- `ST_IDLE`, left through *start* on an accepted write.
- `ST_WAIT_VS`, left through *vs_seen* on a qualified TE pulse.
- `ST_WAIT_LINE`, left through *line_hit* when the HSYNC count reaches the target.
- `ST_XFER`, left through *last_beat* back to idle.

An accepted write goes directly from `ST_IDLE` to `ST_XFER` when the immediate-trigger bit is set (*kick*). In the TE-only mode, `ST_WAIT_VS` goes directly to `ST_XFER` (*vs_go*).

Top module: `tear_xfer_ctrl`

## Requirements
- R1: After reset, `busy`, `px_valid` and `frame_done` are low and `cs_sel` is 0.
- R2: The control word has the enable at bit 0, the bypass at bit 1, the chip select at bits [3:2] and the immediate trigger at bit 4. A write while idle with enable=1, bypass=0, chip select 1 or 2 and a nonzero `pix_total` is accepted: `busy` goes high, and `cs_sel` shows the chosen select, unchanged until the frame ends.
- R3: A write with enable=0, with bypass=1, with chip select 0 or 3, or with `pix_total`=0 leaves the block idle. `cs_sel` never shows 3.
- R4: With the immediate-trigger bit set, `px_valid` is high in the cycle right after the write edge.
- R5: With the immediate-trigger bit clear and `te_line_mode`=0, the transfer starts on a qualified TE pulse. `px_valid` rises N+3 clock edges after the raw TE input becomes active, where N is `vs_width`, or 1 when `vs_width` is 0.
- R6: A pulse on either panel input that is active for fewer than N clocks is ignored.
- R7: Each panel input has its own polarity select: 1 means active high and 0 means active low.
- R8: With `te_line_mode`=1, the block counts qualified HSYNC pulses that arrive after the qualified TE pulse, and starts when the count equals `line_target` (0 to 2047). HSYNC pulses that arrive before TE are not counted.
- R9: `px_valid` is high only during a transfer. A transfer ends after exactly `pix_total` beats, where a beat is a cycle with both `px_valid` and `px_ready` high, whatever the ready pattern.
- R10: In the cycle after the last beat, `frame_done` is high for exactly one clock and `busy` and `px_valid` are already low.
- R11: A control write while `busy` is high, including one with enable=0, has no effect. The running frame keeps its chip select and its pixel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word: bit 0 enable, bit 1 bypass, [3:2] chip select, bit 4 immediate trigger |
| pix_total | input | CNT_W | Pixels in the region, sampled when the write is accepted |
| te_line_mode | input | 1 | 0: start on TE alone; 1: start on TE followed by a line match |
| line_target | input | LINE_W | HSYNC count after TE at which the transfer starts |
| vs_width | input | WID_W | Minimum TE pulse width in clocks (0 is treated as 1) |
| hs_width | input | WID_W | Minimum HSYNC pulse width in clocks (0 is treated as 1) |
| vs_act_high | input | 1 | TE polarity, 1 for active high |
| hs_act_high | input | 1 | HSYNC polarity, 1 for active high |
| te_in | input | 1 | Raw tearing-effect input from the panel |
| hs_in | input | 1 | Raw horizontal sync input from the panel |
| px_valid | output | 1 | A beat is offered to the bus engine |
| px_ready | input | 1 | The bus engine accepts the beat |
| cs_sel | output | 2 | Chip select of the running frame, 0 when idle |
| busy | output | 1 | Enable state: high from an accepted write to frame done |
| frame_done | output | 1 | One-clock pulse at the end of a frame |

## Verification
The bench drives inputs and samples outputs on the falling clock edge, and counts each due cycle in rising edges from the stimulus.

| Stimulus | Result | When it is due |
|---|---|---|
| Accepted write with the immediate trigger set | `px_valid` high | First edge after the write |
| Raw TE input becomes active | `px_valid` high | N+3 edges later; the bench records the edge where `px_valid` first appears and compares it against that figure across a sweep of widths and pulse lengths |
| Last beat | `frame_done` high, `busy` low | Next edge |
| Line-qualified start | transfer begins | Two more edges after the third flop stage of the HSYNC path; the bench waits a fixed margin after each pulse and checks that only the target pulse starts the transfer |

// File: rtl/tear_xfer_pkg.sv
package tear_xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_VS,
        ST_WAIT_LINE,
        ST_XFER
    } xfer_state_t;

    localparam int CTL_W     = 5;
    localparam int CTL_EN    = 0;
    localparam int CTL_BYP   = 1;
    localparam int CTL_CS_LO = 2;
    localparam int CTL_CS_HI = 3;
    localparam int CTL_ITRIG = 4;
endpackage

// File: rtl/tear_pulse_qual.sv
// Synchronizes a raw panel input, applies its polarity, and emits a
// one-cycle hit once the active level has lasted the programmed width.
module tear_pulse_qual #(
    parameter int WID_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic             act_high,
    input  logic [WID_W-1:0] width,
    output logic             hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [WID_W-1:0]       run_q;
    logic [WID_W-1:0]       need;
    logic                   active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
        end
    end

    assign active = act_high ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];
    assign need   = (width == '0) ? WID_W'(1) : width;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            hit   <= 1'b0;
        end else begin
            if (!active) begin
                run_q <= '0;
            end else if (run_q != '1) begin
                run_q <= run_q + WID_W'(1);
            end
            hit <= active && (run_q == need - WID_W'(1));
        end
    end
endmodule

// File: rtl/tear_pix_cnt.sv
// Latches the region size at start and flags the final beat.
module tear_pix_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] total_in,
    input  logic             step,
    output logic             last
);
    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q <= '0;
            done_q  <= '0;
        end else if (load) begin
            total_q <= total_in;
            done_q  <= '0;
        end else if (step) begin
            done_q  <= done_q + CNT_W'(1);
        end
    end

    assign last = (done_q == total_q - CNT_W'(1));
endmodule

// File: rtl/tear_line_match.sv
// Counts qualified line pulses after the frame pulse and compares to a target.
module tear_line_match #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [LINE_W-1:0] target,
    output logic              match
);
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (clear) begin
            line_q <= '0;
        end else if (step) begin
            line_q <= line_q + LINE_W'(1);
        end
    end

    assign match = (line_q == target);
endmodule

// File: rtl/tear_xfer_ctrl.sv
module tear_xfer_ctrl
    import tear_xfer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int LINE_W = 11,
    parameter int WID_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic [CNT_W-1:0]  pix_total,
    input  logic              te_line_mode,
    input  logic [LINE_W-1:0] line_target,
    input  logic [WID_W-1:0]  vs_width,
    input  logic [WID_W-1:0]  hs_width,
    input  logic              vs_act_high,
    input  logic              hs_act_high,
    input  logic              te_in,
    input  logic              hs_in,
    output logic              px_valid,
    input  logic              px_ready,
    output logic [1:0]        cs_sel,
    output logic              busy,
    output logic              frame_done
);
    xfer_state_t state_q, state_nx;
    logic [1:0]  cs_q;
    logic [1:0]  wr_cs;
    logic        wr_ok;
    logic        vs_hit, hs_hit;
    logic        last_px, line_hit;
    logic        beat, last_beat;

    assign wr_cs = ctl_wdata[CTL_CS_HI:CTL_CS_LO];
    assign wr_ok = ctl_wr && ctl_wdata[CTL_EN] && !ctl_wdata[CTL_BYP]
                   && (wr_cs == 2'd1 || wr_cs == 2'd2) && (pix_total != '0);

    tear_pulse_qual #(.WID_W(WID_W), .SYNC_STAGES(2)) u_vs_qual (
        .clk(clk), .rst_n(rst_n), .raw(te_in), .act_high(vs_act_high),
        .width(vs_width), .hit(vs_hit)
    );

    tear_pulse_qual #(.WID_W(WID_W), .SYNC_STAGES(2)) u_hs_qual (
        .clk(clk), .rst_n(rst_n), .raw(hs_in), .act_high(hs_act_high),
        .width(hs_width), .hit(hs_hit)
    );

    tear_line_match #(.LINE_W(LINE_W)) u_line (
        .clk(clk), .rst_n(rst_n), .clear(state_q != ST_WAIT_LINE),
        .step(hs_hit), .target(line_target), .match(line_hit)
    );

    assign beat      = (state_q == ST_XFER) && px_ready;
    assign last_beat = beat && last_px;

    tear_pix_cnt #(.CNT_W(CNT_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .load((state_q == ST_IDLE) && wr_ok),
        .total_in(pix_total), .step(beat), .last(last_px)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions: start/kick, vs_seen/vs_go, line_hit, last_beat
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_ok) begin
                    state_nx = ctl_wdata[CTL_ITRIG] ? ST_XFER : ST_WAIT_VS;
                end
            end
            ST_WAIT_VS: begin
                if (vs_hit) begin
                    state_nx = te_line_mode ? ST_WAIT_LINE : ST_XFER;
                end
            end
            ST_WAIT_LINE: begin
                if (line_hit) begin
                    state_nx = ST_XFER;
                end
            end
            ST_XFER: begin
                if (last_beat) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q       <= 2'd0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= last_beat;
            if ((state_q == ST_IDLE) && wr_ok) begin
                cs_q <= wr_cs;
            end else if (last_beat) begin
                cs_q <= 2'd0;
            end
        end
    end

    assign px_valid = (state_q == ST_XFER);
    assign busy     = (state_q != ST_IDLE);
    assign cs_sel   = cs_q;
endmodule

// File: rtl/tear_xfer_chk.sv
module tear_xfer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       px_valid,
    input logic       px_ready,
    input logic [1:0] cs_sel,
    input logic       frame_done
);
    assert_done_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_done_after_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(px_valid && px_ready));

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy);

    assert_valid_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> busy);

    assert_cs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_sel));

    assert_cs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_sel == 2'd0));

    assert_cs_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_sel != 2'd3);
endmodule

bind tear_xfer_ctrl tear_xfer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .px_valid(px_valid),
    .px_ready(px_ready), .cs_sel(cs_sel), .frame_done(frame_done)
);

// File: tb/sim_tear_xfer_ctrl.sv
module sim_tear_xfer_ctrl;
    localparam int CNT_W  = 16;
    localparam int LINE_W = 11;
    localparam int WID_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_wr = 1'b0;
    logic [4:0]        ctl_wdata = '0;
    logic [CNT_W-1:0]  pix_total = '0;
    logic              te_line_mode = 1'b0;
    logic [LINE_W-1:0] line_target = '0;
    logic [WID_W-1:0]  vs_width = WID_W'(1);
    logic [WID_W-1:0]  hs_width = WID_W'(1);
    logic              vs_act_high = 1'b1;
    logic              hs_act_high = 1'b1;
    logic              te_in = 1'b0;
    logic              hs_in = 1'b0;
    logic              px_ready = 1'b0;
    logic              px_valid;
    logic [1:0]        cs_sel;
    logic              busy;
    logic              frame_done;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    tear_xfer_ctrl #(.CNT_W(CNT_W), .LINE_W(LINE_W), .WID_W(WID_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .pix_total(pix_total), .te_line_mode(te_line_mode),
        .line_target(line_target), .vs_width(vs_width), .hs_width(hs_width),
        .vs_act_high(vs_act_high), .hs_act_high(hs_act_high),
        .te_in(te_in), .hs_in(hs_in), .px_valid(px_valid), .px_ready(px_ready),
        .cs_sel(cs_sel), .busy(busy), .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic itrig, input logic [1:0] cs, input logic byp,
                          input logic en, input int cnt);
        @(negedge clk);
        pix_total = CNT_W'(cnt);
        ctl_wdata = {itrig, cs, byp, en};
        ctl_wr    = 1'b1;
        @(negedge clk);
        ctl_wr    = 1'b0;
    endtask

    task automatic drain(input int want, input int period, input string req);
        int  cnt  = 0;
        bit  seen = 1'b0;
        for (int cyc = 0; cyc < 3000 && !seen; cyc++) begin
            if (frame_done) begin
                seen = 1'b1;
                chk(cnt == want, req, cnt, want);
                chk(!busy && !px_valid, "R10", int'(busy) + int'(px_valid), 0);
            end else begin
                px_ready = (period <= 1) || (cyc % period != 0);
                if (px_valid && px_ready) cnt++;
                @(negedge clk);
            end
        end
        chk(seen, "R10", int'(seen), 1);
        px_ready = 1'b0;
        @(negedge clk);
        chk(!frame_done, "R10", int'(frame_done), 0);
    endtask

    task automatic mode1_case(input int w, input int len);
        int first = 0;
        int need  = (w == 0) ? 1 : w;
        int exp   = (len >= need) ? need + 3 : 0;
        vs_width     = WID_W'(w);
        te_line_mode = 1'b0;
        wr_ctl(1'b0, 2'd1, 1'b0, 1'b1, 3);
        chk(busy && !px_valid, "R5", int'(px_valid), 0);
        te_in = 1'b1;
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            if (k == len) te_in = 1'b0;
            if (px_valid && first == 0) first = k;
        end
        chk(first == exp, (len >= need) ? "R5" : "R6", first, exp);
        if (len < need) begin
            te_in = 1'b1;
            repeat (need + 1) @(negedge clk);
            te_in = 1'b0;
            repeat (4) @(negedge clk);
            chk(px_valid, "R6", int'(px_valid), 1);
        end
        drain(3, 1, "R9");
    endtask

    task automatic hs_pulse(input logic act);
        hs_in = act;
        repeat (3) @(negedge clk);
        hs_in = ~act;
        repeat (6) @(negedge clk);
    endtask

    task automatic mode2_case(input int tgt, input logic act, input string req);
        hs_act_high  = act;
        hs_in        = ~act;
        vs_width     = WID_W'(2);
        hs_width     = WID_W'(2);
        te_line_mode = 1'b1;
        line_target  = LINE_W'(tgt);
        repeat (6) @(negedge clk);
        wr_ctl(1'b0, 2'd2, 1'b0, 1'b1, 2);
        hs_pulse(act);
        hs_pulse(act);
        chk(!px_valid, "R8", int'(px_valid), 0);
        te_in = 1'b1;
        repeat (4) @(negedge clk);
        te_in = 1'b0;
        repeat (6) @(negedge clk);
        chk(px_valid == (tgt == 0), req, int'(px_valid), int'(tgt == 0));
        for (int i = 1; i <= tgt; i++) begin
            hs_pulse(act);
            chk(px_valid == (i == tgt), req, int'(px_valid), int'(i == tgt));
        end
        drain(2, 2, "R9");
        hs_act_high = 1'b1;
        hs_in       = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !px_valid && !frame_done && cs_sel == 2'd0, "R1",
            int'(busy) + int'(px_valid) + int'(frame_done) + int'(cs_sel), 0);

        // R3: rejected writes
        wr_ctl(1'b1, 2'd1, 1'b0, 1'b0, 4);
        chk(!busy && !px_valid, "R3", int'(busy), 0);
        wr_ctl(1'b1, 2'd1, 1'b1, 1'b1, 4);
        chk(!busy && !px_valid, "R3", int'(busy), 0);
        wr_ctl(1'b1, 2'd0, 1'b0, 1'b1, 4);
        chk(!busy && !px_valid, "R3", int'(busy), 0);
        wr_ctl(1'b1, 2'd3, 1'b0, 1'b1, 4);
        chk(!busy && !px_valid, "R3", int'(busy), 0);
        wr_ctl(1'b1, 2'd1, 1'b0, 1'b1, 0);
        chk(!busy && !px_valid, "R3", int'(busy), 0);

        // R4 / R2: immediate trigger with each chip select
        wr_ctl(1'b1, 2'd1, 1'b0, 1'b1, 7);
        chk(px_valid, "R4", int'(px_valid), 1);
        chk(cs_sel == 2'd1, "R2", int'(cs_sel), 1);
        drain(7, 3, "R9");
        wr_ctl(1'b1, 2'd2, 1'b0, 1'b1, 1);
        chk(busy && cs_sel == 2'd2, "R2", int'(cs_sel), 2);
        drain(1, 1, "R9");

        // R11: writes during a frame are ignored
        wr_ctl(1'b1, 2'd1, 1'b0, 1'b1, 5);
        wr_ctl(1'b1, 2'd2, 1'b0, 1'b1, 9);
        chk(cs_sel == 2'd1, "R11", int'(cs_sel), 1);
        wr_ctl(1'b0, 2'd0, 1'b0, 1'b0, 0);
        chk(busy && px_valid, "R11", int'(busy), 1);
        drain(5, 1, "R11");

        // R9: pixel count sweep over sizes and ready patterns
        for (int n = 1; n <= 6; n++) begin
            for (int p = 1; p <= 3; p++) begin
                wr_ctl(1'b1, 2'd1, 1'b0, 1'b1, n);
                drain(n, p, "R9");
            end
        end

        // R5 / R6: TE-only start, width and pulse length sweep
        for (int w = 0; w <= 4; w++) begin
            for (int len = 1; len <= 5; len++) begin
                mode1_case(w, len);
                repeat (4) @(negedge clk);
            end
        end

        // R7: active-low TE
        vs_width    = WID_W'(2);
        vs_act_high = 1'b0;
        te_in       = 1'b1;
        repeat (6) @(negedge clk);
        te_line_mode = 1'b0;
        wr_ctl(1'b0, 2'd1, 1'b0, 1'b1, 2);
        repeat (10) @(negedge clk);
        chk(!px_valid, "R7", int'(px_valid), 0);
        te_in = 1'b0;
        repeat (3) @(negedge clk);
        te_in = 1'b1;
        repeat (6) @(negedge clk);
        chk(px_valid, "R7", int'(px_valid), 1);
        drain(2, 1, "R9");
        vs_act_high = 1'b1;
        te_in       = 1'b0;
        repeat (6) @(negedge clk);

        // R8: line-qualified start, target sweep; R7 on HSYNC polarity
        for (int t = 0; t <= 4; t++) begin
            mode2_case(t, 1'b1, "R8");
        end
        mode2_case(2, 1'b0, "R7");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule